// File: doc/BRIEF.md
# Streaming Image-Header Parser

This block reads the leading bytes of a configuration image as they go past on a byte stream, without buffering the image. Each byte arrives with a valid strobe and its byte position in the image. From these bytes the block finds the length of the fixed header and the number of entries in the lookup table that follows it. It then walks that table to locate two regions: the component-size array and the payload.

Once the table has given both locations, the block waits for the component-size array. It unpacks the array's 22-bit fields, which are packed back to back, as the bytes stream in. It adds the fields up and scales the total into a payload length in bytes. The result is presented as a payload start offset and a payload byte count together with a one-cycle completion pulse. A malformed image raises a sticky error flag instead. A byte at position 0 begins a new image, so a host can parse images back to back.

Top module: `img_hdr_parser`

## Requirements
- R1: After reset, `done_o` and `err_o` are 0, and `pay_start_o` and `pay_len_o` are 0.
- R2: The byte at position 24 is the base header length H. If H < 57, `err_o` is set in the cycle after that byte.
- R3: The byte at position H-1 is the table entry count K. The table occupies positions H to H+9K-1. If K = 0, `err_o` is set.
- R4: Each table entry is 9 bytes. Byte 0 is a tag. Bytes 1 to 4 are a 32-bit offset, least significant byte first. Bytes 5 to 8 are unused. Tag 8 gives the payload start, which appears on `pay_start_o`. Tag 5 gives the array start A. Entries with any other tag have no effect on the result.
- R5: Scanning ends after the first entry at which both tags have been seen. Later entries are not interpreted.
- R6: If either tag is still missing after all K entries, `err_o` is set and no `done_o` pulse occurs.
- R7: If A or the payload start is less than H+9K, `err_o` is set and no `done_o` pulse occurs.
- R8: The component count N is the 16-bit value at positions 55 (low byte) and 56 (high byte). Component i occupies bits 22i to 22i+21 of the array, counted from bit 0 of byte A upward, least significant bit first. `pay_len_o` equals 16 times the sum of the N components. `done_o` is high for exactly one cycle, in the cycle after the last array byte (position A + ceil(22N/8) - 1). When N = 0, the pulse follows the table.
- R9: A valid byte at position 0 restarts parsing and clears `err_o`. `err_o` otherwise holds. `pay_start_o` and `pay_len_o` change only together with a `done_o` pulse, so they hold their values across an erroneous image.
- R10: Bytes presented with `in_valid_i` low are ignored. `in_ready_o` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Byte strobe |
| in_ready_o | output | 1 | Always accepting |
| in_data_i | input | 8 | Image byte |
| in_idx_i | input | IDX_W (32) | Position of the byte in the image |
| pay_start_o | output | 32 | Payload start offset |
| pay_len_o | output | 42 | Payload length in bytes |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Malformed-image flag |

## Verification
The bench sweeps the component count from 0 to 12 in four image shapes. These counts cover every bit alignment the fields can take across byte edges, and N = 0 separates the empty-array path from the unpacking path. The shapes vary the header length, the table size and the position of each tag. Some shapes insert idle cycles with a stale byte on the bus, and some place entries after the stopping point that would force an error if they were read. These shapes separate correct early stopping and valid qualification from a scan that reads too far or counts stale bytes. An all-ones pattern and a 300-component image test the sum width and the high byte of the count. Each error class is then injected separately, with the outputs checked to hold. A clean image follows to confirm the restart.

// File: rtl/hdr_parse_pkg.sv
package hdr_parse_pkg;
  typedef enum logic [1:0] {PS_HDR, PS_TBL, PS_ARR, PS_FIN} parse_st_e;
endpackage

// File: rtl/hdr_lut_scan.sv
module hdr_lut_scan #(
  parameter int REC_BYTES = 9,
  parameter int OFF_BYTES = 4,
  parameter int ID_ARR    = 5,
  parameter int ID_PAY    = 8,
  localparam int OFF_W    = 8 * OFF_BYTES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             vld_i,
  input  logic [7:0]       byte_i,
  output logic             rec_end_o,
  output logic             arr_hit_o,
  output logic             pay_hit_o,
  output logic [OFF_W-1:0] arr_start_o,
  output logic [OFF_W-1:0] pay_start_o
);
  localparam int POS_W = $clog2(REC_BYTES);

  logic [POS_W-1:0] pos_q;
  logic [7:0]       id_q;
  logic [OFF_W-1:0] off_q, arr_q, pay_q;
  logic             arr_f_q, pay_f_q, is_arr, is_pay;

  assign rec_end_o   = vld_i && (pos_q == POS_W'(REC_BYTES - 1));
  assign is_arr      = rec_end_o && (id_q == 8'(ID_ARR));
  assign is_pay      = rec_end_o && (id_q == 8'(ID_PAY));
  // results include the entry completing this cycle
  assign arr_hit_o   = arr_f_q || is_arr;
  assign pay_hit_o   = pay_f_q || is_pay;
  assign arr_start_o = is_arr ? off_q : arr_q;
  assign pay_start_o = is_pay ? off_q : pay_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0; id_q <= '0; off_q <= '0; arr_q <= '0; pay_q <= '0;
      arr_f_q <= 1'b0; pay_f_q <= 1'b0;
    end else if (clear_i) begin
      pos_q <= '0; id_q <= '0; off_q <= '0; arr_q <= '0; pay_q <= '0;
      arr_f_q <= 1'b0; pay_f_q <= 1'b0;
    end else if (vld_i) begin
      pos_q <= rec_end_o ? '0 : pos_q + POS_W'(1);
      if (pos_q == '0) id_q <= byte_i;
      for (int b = 0; b < OFF_BYTES; b++)
        if (pos_q == POS_W'(b + 1)) off_q[b*8 +: 8] <= byte_i;
      if (is_arr) begin arr_q <= off_q; arr_f_q <= 1'b1; end
      if (is_pay) begin pay_q <= off_q; pay_f_q <= 1'b1; end
    end
  end
endmodule

// File: rtl/hdr_bit_unpack.sv
module hdr_bit_unpack #(
  parameter int FLD_W = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             vld_i,
  input  logic [7:0]       byte_i,
  output logic             fld_vld_o,
  output logic [FLD_W-1:0] fld_o
);
  localparam int ACC_W = FLD_W + 7;
  localparam int NB_W  = $clog2(ACC_W + 1);

  logic [ACC_W-1:0] acc_q, merged;
  logic [NB_W-1:0]  nb_q, nb_sum;

  // bits above nb_q are always zero, so OR-merge is exact
  assign merged    = acc_q | (ACC_W'(byte_i) << nb_q);
  assign nb_sum    = nb_q + NB_W'(8);
  assign fld_vld_o = vld_i && (nb_sum >= NB_W'(FLD_W));
  assign fld_o     = merged[FLD_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0; nb_q <= '0;
    end else if (clear_i) begin
      acc_q <= '0; nb_q <= '0;
    end else if (vld_i) begin
      if (fld_vld_o) begin
        acc_q <= merged >> FLD_W;
        nb_q  <= nb_sum - NB_W'(FLD_W);
      end else begin
        acc_q <= merged;
        nb_q  <= nb_sum;
      end
    end
  end
endmodule

// File: rtl/img_hdr_parser.sv
module img_hdr_parser
  import hdr_parse_pkg::*;
#(
  parameter int IDX_W       = 32,
  parameter int CNT_BYTES   = 2,
  parameter int FLD_W       = 22,
  parameter int FRAME_SHIFT = 4,
  parameter int HLEN_POS    = 24,
  parameter int CNT_POS     = 55,
  parameter int MIN_HDR     = 57,
  parameter int REC_BYTES   = 9,
  parameter int OFF_BYTES   = 4,
  parameter int ID_ARR      = 5,
  parameter int ID_PAY      = 8,
  localparam int OFF_W      = 8 * OFF_BYTES,
  localparam int CNT_W      = 8 * CNT_BYTES,
  localparam int SUM_W      = FLD_W + CNT_W,
  localparam int LEN_W      = SUM_W + FRAME_SHIFT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [7:0]       in_data_i,
  input  logic [IDX_W-1:0] in_idx_i,
  output logic [OFF_W-1:0] pay_start_o,
  output logic [LEN_W-1:0] pay_len_o,
  output logic             done_o,
  output logic             err_o
);
  localparam int CMP_W = (IDX_W > OFF_W ? IDX_W : OFF_W) + 1;

  parse_st_e        st_q;
  logic [7:0]       hdr_len_q, rec_cnt_q, rec_left_q;
  logic [CNT_W-1:0] cnt_q, comp_left_q;
  logic [SUM_W-1:0] sum_q, sum_nx;
  logic [OFF_W-1:0] start_q, tbl_end, arr_start, pay_start;
  logic [LEN_W-1:0] len_q;
  logic             err_q, done_q;
  logic             restart, hdr_end_hit, scan_vld, unpk_vld;
  logic             rec_end, arr_hit, pay_hit, both, tbl_stop, place_bad;
  logic             fld_vld;
  logic [FLD_W-1:0] fld;

  assign in_ready_o  = 1'b1;
  assign restart     = in_valid_i && (in_idx_i == '0);
  assign hdr_end_hit = (in_idx_i > IDX_W'(HLEN_POS)) &&
                       (in_idx_i == IDX_W'(hdr_len_q) - IDX_W'(1));
  assign scan_vld    = in_valid_i && !restart && (st_q == PS_TBL);
  assign unpk_vld    = in_valid_i && !restart && (st_q == PS_ARR) &&
                       (CMP_W'(in_idx_i) >= CMP_W'(arr_start));

  hdr_lut_scan #(
    .REC_BYTES(REC_BYTES), .OFF_BYTES(OFF_BYTES), .ID_ARR(ID_ARR), .ID_PAY(ID_PAY)
  ) u_scan (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(restart), .vld_i(scan_vld),
    .byte_i(in_data_i), .rec_end_o(rec_end), .arr_hit_o(arr_hit),
    .pay_hit_o(pay_hit), .arr_start_o(arr_start), .pay_start_o(pay_start)
  );

  hdr_bit_unpack #(.FLD_W(FLD_W)) u_unpk (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(restart), .vld_i(unpk_vld),
    .byte_i(in_data_i), .fld_vld_o(fld_vld), .fld_o(fld)
  );

  assign tbl_end   = OFF_W'(hdr_len_q) + OFF_W'(REC_BYTES) * OFF_W'(rec_cnt_q);
  assign both      = arr_hit && pay_hit;
  assign tbl_stop  = rec_end && (both || rec_left_q == 8'd1);
  assign place_bad = (arr_start < tbl_end) || (pay_start < tbl_end);
  assign sum_nx    = sum_q + SUM_W'(fld);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= PS_HDR; hdr_len_q <= '0; rec_cnt_q <= '0; rec_left_q <= '0;
      cnt_q <= '0; comp_left_q <= '0; sum_q <= '0;
      start_q <= '0; len_q <= '0; err_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (restart) begin
        st_q <= PS_HDR; hdr_len_q <= '0; rec_cnt_q <= '0; rec_left_q <= '0;
        cnt_q <= '0; comp_left_q <= '0; sum_q <= '0; err_q <= 1'b0;
      end else if (in_valid_i) begin
        unique case (st_q)
          PS_HDR: begin
            if (in_idx_i == IDX_W'(HLEN_POS)) begin
              hdr_len_q <= in_data_i;
              if (in_data_i < 8'(MIN_HDR)) begin err_q <= 1'b1; st_q <= PS_FIN; end
            end
            for (int b = 0; b < CNT_BYTES; b++)
              if (in_idx_i == IDX_W'(CNT_POS + b)) cnt_q[b*8 +: 8] <= in_data_i;
            if (hdr_end_hit) begin
              rec_cnt_q  <= in_data_i;
              rec_left_q <= in_data_i;
              if (in_data_i == '0) begin err_q <= 1'b1; st_q <= PS_FIN; end
              else st_q <= PS_TBL;
            end
          end
          PS_TBL: if (rec_end) begin
            rec_left_q <= rec_left_q - 8'd1;
            if (tbl_stop) begin
              if (!both || place_bad) begin
                err_q <= 1'b1; st_q <= PS_FIN;
              end else if (cnt_q == '0) begin
                done_q <= 1'b1; start_q <= pay_start; len_q <= '0; st_q <= PS_FIN;
              end else begin
                comp_left_q <= cnt_q; sum_q <= '0; st_q <= PS_ARR;
              end
            end
          end
          PS_ARR: if (fld_vld) begin
            sum_q       <= sum_nx;
            comp_left_q <= comp_left_q - CNT_W'(1);
            if (comp_left_q == CNT_W'(1)) begin
              done_q  <= 1'b1;
              start_q <= pay_start;
              len_q   <= LEN_W'(sum_nx) << FRAME_SHIFT;
              st_q    <= PS_FIN;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign pay_start_o = start_q;
  assign pay_len_o   = len_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
endmodule

// File: rtl/hdr_parser_chk.sv
module hdr_parser_chk #(
  parameter int IDX_W = 32,
  parameter int OFF_W = 32,
  parameter int LEN_W = 42
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic [IDX_W-1:0] in_idx_i,
  input logic [OFF_W-1:0] pay_start_o,
  input logic [LEN_W-1:0] pay_len_o,
  input logic             done_o,
  input logic             err_o
);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R6
  done_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  // R9
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !(in_valid_i && in_idx_i == '0)) |=> err_o);

  // R9
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(pay_len_o) || !$stable(pay_start_o)) |-> done_o);

  // R10
  err_on_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(in_valid_i));
endmodule

bind img_hdr_parser hdr_parser_chk #(
  .IDX_W(IDX_W), .OFF_W(OFF_W), .LEN_W(LEN_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_idx_i(in_idx_i),
  .pay_start_o(pay_start_o), .pay_len_o(pay_len_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/sim_img_hdr_parser.sv
`timescale 1ns/1ps
module sim_img_hdr_parser;
  localparam int IDX_W = 32;
  localparam int LEN_W = 42;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic             in_valid = 1'b0, in_ready;
  logic [7:0]       in_data = '0;
  logic [IDX_W-1:0] in_idx = '0;
  logic [31:0]      pay_start;
  logic [LEN_W-1:0] pay_len;
  logic             done, err;

  img_hdr_parser u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .in_idx_i(in_idx), .pay_start_o(pay_start),
    .pay_len_o(pay_len), .done_o(done), .err_o(err)
  );

  logic [7:0] img [0:1023];
  int  img_len, n_chk = 0, n_bad = 0, done_cnt = 0;
  bit  finished = 0;
  logic last_done, err_after_restart;
  longint exp_sum, exp_p;

  always @(negedge clk) if (rst_n && done) done_cnt++;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // mode 0 good, 1 array inside table, 2 payload inside table
  task automatic build(input int h, input int k, input int r5, input int r8,
                       input int agap, input int n, input int seed, input int mode);
    int tbl_end, arr_bytes, a, p, hi;
    tbl_end   = h + 9 * k;
    arr_bytes = (22 * n + 7) / 8;
    a = (mode == 1) ? h : tbl_end + agap;
    p = (mode == 2) ? tbl_end - 1 : a + arr_bytes + 3;
    img_len = (a + arr_bytes > tbl_end) ? a + arr_bytes : tbl_end;
    for (int j = 0; j < img_len; j++) img[j] = 8'((j * 37 + 11) & 255);
    exp_sum = 0;
    for (int j = a; j < a + arr_bytes; j++) img[j] = 8'hFF;
    for (int i = 0; i < n; i++) begin
      logic [21:0] sz;
      sz = (seed < 0) ? 22'h3FFFFF : 22'((seed * 40503 + i * 977 + 12345 * i * i) & 32'h3FFFFF);
      exp_sum += longint'(sz);
      for (int b = 0; b < 22; b++) begin
        int bp;
        bp = 22 * i + b;
        img[a + bp / 8][bp % 8] = sz[b];
      end
    end
    img[24] = 8'(h);
    img[55] = 8'(n & 255);
    img[56] = 8'((n >> 8) & 255);
    if (h >= 26) img[h - 1] = 8'(k);
    hi = (r5 > r8) ? r5 : r8;
    for (int r = 0; r < k; r++) begin
      int base, off;
      logic [7:0] id;
      bit late;
      base = h + 9 * r;
      late = (r5 >= 0) && (r8 >= 0) && (r > hi);
      if (r == r5)      begin id = 8'd5; off = a; end
      else if (r == r8) begin id = 8'd8; off = p; end
      else if (late)    begin id = 8'd5; off = 0; end
      else              begin id = (r == 0) ? 8'd0 : 8'(9 + r); off = 1; end
      img[base] = id;
      for (int b = 0; b < 4; b++) img[base + 1 + b] = 8'((off >> (8 * b)) & 255);
    end
    exp_p = longint'(p);
  endtask

  task automatic drive(input bit gap_en);
    done_cnt = 0;
    for (int i = 0; i < img_len; i++) begin
      @(negedge clk);
      if (i == 1) err_after_restart = err;
      if (gap_en && (i % 5 == 2)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1; in_data = img[i]; in_idx = IDX_W'(i);
    end
    @(negedge clk);
    in_valid  = 1'b0;
    last_done = done;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_good(input string tag, input int h, input int k, input int r5,
                          input int r8, input int agap, input int n, input int seed,
                          input bit gap_en);
    build(h, k, r5, r8, agap, n, seed, 0);
    drive(gap_en);
    chk({tag, " R8 one done pulse"}, 64'(done_cnt), 64'd1);
    chk({tag, " R6/R7 no error"}, 64'(err), 64'd0);
    chk({tag, " R4 payload start"}, 64'(pay_start), 64'(exp_p));
    chk({tag, gap_en ? " R8 R10 length with idle gaps" : " R8 length"},
        64'(pay_len), 64'(exp_sum * 16));
    if (n > 0) chk({tag, " R8 done follows last array byte"}, 64'(last_done), 64'd1);
    chk({tag, " R9 restart clears error"}, 64'(err_after_restart), 64'd0);
  endtask

  task automatic run_bad(input string tag, input int h, input int k, input int r5,
                         input int r8, input int n, input int mode);
    logic [31:0] old_p;
    logic [LEN_W-1:0] old_l;
    old_p = pay_start; old_l = pay_len;
    build(h, k, r5, r8, 1, n, 7, mode);
    drive(1'b0);
    chk({tag, " error flag"}, 64'(err), 64'd1);
    chk({tag, " no done pulse"}, 64'(done_cnt), 64'd0);
    chk({tag, " R9 start held"}, 64'(pay_start), 64'(old_p));
    chk({tag, " R9 length held"}, 64'(pay_len), 64'(old_l));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", 64'(done), 64'd0);
    chk("R1 err after reset", 64'(err), 64'd0);
    chk("R1 start after reset", 64'(pay_start), 64'd0);
    chk("R1 length after reset", 64'(pay_len), 64'd0);
    chk("R10 ready", 64'(in_ready), 64'd1);

    for (int n = 0; n <= 12; n++) begin
      run_good("R8 sweep v0", 60, 2, 0, 1, 0, n, n * 13, 1'b0);
      run_good("R4 ignored tags v1", 71, 4, 2, 0, 3, n, n * 13 + 1, 1'b1);
      run_good("R5 early stop v2", 64, 5, 1, 2, 1, n, n * 13 + 2, 1'b1);
      run_good("R8 all ones v3", 90, 3, 2, 1, 2, n, -1, 1'b0);
    end
    run_good("R8 count high byte", 60, 2, 1, 0, 0, 300, -1, 1'b0);

    run_bad("R2 short header", 40, 1, 0, -1, 1, 0);
    run_bad("R3 empty table", 60, 0, -1, -1, 1, 0);
    run_bad("R6 missing payload tag", 60, 3, 1, -1, 2, 0);
    run_bad("R6 missing array tag", 60, 3, -1, 0, 2, 0);
    run_bad("R7 array inside table", 60, 2, 0, 1, 2, 1);
    run_bad("R7 payload inside table", 60, 2, 0, 1, 2, 2);
    run_good("R9 recovery after error", 64, 3, 2, 1, 0, 5, 99, 1'b1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule